// File: doc/BRIEF.md
# Output Amplitude Keying Controller

This block produces the 14-bit amplitude multiplier word that feeds the output scaling stage of a direct digital synthesizer. A single keying input decides whether the carrier is on or off. In manual mode the multiplier jumps straight between zero and a programmed full-on level. In automatic mode a dedicated amplitude-only ramp generator moves the word linearly toward that level or toward zero, by a programmable increment once every programmable number of clocks.

While keying is enabled, the block's ramp value is the only amplitude that reaches the output, and every other amplitude source is locked out. While keying is disabled, the amplitude word from the other sources passes to the output unchanged. The internal ramp is also cleared, so that a later enable starts from silence.

Top module: `osk_ctrl`

## Requirements
- R1: With `osk_en_i` low, `amp_o` equals `amp_ext_i` in the same cycle, for any value of the other inputs.
- R2: With keying enabled in manual mode (`auto_mode_i` low) and `key_i` high, `amp_o` equals `scale_i` one clock after the inputs are applied.
- R3: With keying enabled in manual mode and `key_i` low, `amp_o` is 0 one clock later. `amp_ext_i` never reaches the output while `osk_en_i` is high.
- R4: In automatic mode (`auto_mode_i` high) with `key_i` high, the ramp rises by `step_i` on each step event. A step event occurs once every `ivl_i` clocks, counted from the clock on which automatic operation began.
- R5: A rising ramp stops at exactly `scale_i` and never exceeds it.
- R6: In automatic mode with `key_i` low, the ramp falls by `step_i` on each step event and stops at exactly 0, with no wrap.
- R7: If `scale_i` is lowered below the current ramp value while `key_i` is high in automatic mode, the output takes the new `scale_i` at the next step event.
- R8: An `ivl_i` of 0 behaves like 1, which means a step event occurs on every clock.
- R9: After reset the ramp value is 0, so `amp_o` reads 0 with keying enabled.
- R10: Dropping `osk_en_i` clears the ramp and the interval count. A later enable in automatic mode starts from 0, and its first step comes a full interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osk_en_i | input | 1 | Keying enable; when high, the ramp owns the amplitude |
| auto_mode_i | input | 1 | 1 = automatic ramp, 0 = manual switch |
| key_i | input | 1 | Keying input: 1 = carrier on, 0 = carrier off |
| scale_i | input | 14 | Full-on amplitude level |
| step_i | input | 14 | Ramp increment per step event |
| ivl_i | input | 16 | Clocks between step events (0 treated as 1) |
| amp_ext_i | input | 14 | Amplitude word from the other sources |
| amp_o | output | 14 | Amplitude multiplier word |

## Verification
The hardest case to reach from the ports is a scale level lowered underneath a ramp that is still rising or already parked at the old level. That case needs automatic mode, the key held high for many intervals, and then a scale change that lands between two step events. The directed sequence builds such a ramp with a short interval, parks it at the old level, and then drops the level mid-interval. A random phase then mixes small intervals and random scale changes with key flips. Every cycle of both phases is compared against a cycle-level reference model in the bench, so snaps, clamps and interval phases are all covered by the comparison.

// File: rtl/osk_pkg.sv
package osk_pkg;
    parameter int AMP_W = 14;
    parameter int IVL_W = 16;
endpackage

// File: rtl/osk_tick.sv
module osk_tick #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [IVL_W-1:0] ivl_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
    } tick_st_t;

    tick_st_t         st_d, st_q;
    logic [IVL_W-1:0] ivl_eff;

    always_comb begin
        st_d    = st_q;
        ivl_eff = (ivl_i == '0) ? IVL_W'(1) : ivl_i;
        tick_o  = run_i && (st_q.cnt >= ivl_eff - IVL_W'(1));
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + IVL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/osk_ramp.sv
module osk_ramp #(
    parameter int AMP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             auto_i,
    input  logic             key_i,
    input  logic             tick_i,
    input  logic [AMP_W-1:0] scale_i,
    input  logic [AMP_W-1:0] step_i,
    output logic [AMP_W-1:0] ramp_o
);
    typedef struct packed {
        logic [AMP_W-1:0] ramp;
    } ramp_st_t;

    ramp_st_t         st_d, st_q;
    logic [AMP_W-1:0] headroom;

    always_comb begin
        st_d     = st_q;
        headroom = '0;
        if (!en_i) begin
            st_d.ramp = '0;
        end else if (!auto_i) begin
            st_d.ramp = key_i ? scale_i : '0;
        end else if (tick_i) begin
            if (key_i) begin
                if (st_q.ramp >= scale_i) begin
                    st_d.ramp = scale_i;
                end else begin
                    headroom  = scale_i - st_q.ramp;
                    st_d.ramp = st_q.ramp + ((step_i > headroom) ? headroom : step_i);
                end
            end else begin
                st_d.ramp = (st_q.ramp > step_i) ? (st_q.ramp - step_i) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ramp_o = st_q.ramp;
endmodule

// File: rtl/osk_mux.sv
module osk_mux #(
    parameter int AMP_W = 14
) (
    input  logic             en_i,
    input  logic [AMP_W-1:0] ramp_i,
    input  logic [AMP_W-1:0] ext_i,
    output logic [AMP_W-1:0] amp_o
);
    always_comb begin
        amp_o = en_i ? ramp_i : ext_i;
    end
endmodule

// File: rtl/osk_ctrl.sv
module osk_ctrl #(
    parameter int AMP_W = osk_pkg::AMP_W,
    parameter int IVL_W = osk_pkg::IVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osk_en_i,
    input  logic             auto_mode_i,
    input  logic             key_i,
    input  logic [AMP_W-1:0] scale_i,
    input  logic [AMP_W-1:0] step_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic [AMP_W-1:0] amp_ext_i,
    output logic [AMP_W-1:0] amp_o
);
    logic             tick;
    logic             run_auto;
    logic [AMP_W-1:0] ramp;

    assign run_auto = osk_en_i && auto_mode_i;

    osk_tick #(.IVL_W(IVL_W)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_auto),
        .ivl_i  (ivl_i),
        .tick_o (tick)
    );

    osk_ramp #(.AMP_W(AMP_W)) ramp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (osk_en_i),
        .auto_i  (auto_mode_i),
        .key_i   (key_i),
        .tick_i  (tick),
        .scale_i (scale_i),
        .step_i  (step_i),
        .ramp_o  (ramp)
    );

    osk_mux #(.AMP_W(AMP_W)) mux_i (
        .en_i   (osk_en_i),
        .ramp_i (ramp),
        .ext_i  (amp_ext_i),
        .amp_o  (amp_o)
    );
endmodule

// File: rtl/osk_ctrl_chk.sv
module osk_ctrl_chk #(
    parameter int AMP_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osk_en_i,
    input logic             auto_mode_i,
    input logic             key_i,
    input logic [AMP_W-1:0] scale_i,
    input logic [AMP_W-1:0] step_i,
    input logic [AMP_W-1:0] amp_o
);
    // R2
    manual_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osk_en_i && !auto_mode_i && key_i) && osk_en_i) |-> (amp_o == $past(scale_i)));

    // R3
    manual_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osk_en_i && !auto_mode_i && !key_i) && osk_en_i) |-> (amp_o == '0));

    // R5
    rise_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osk_en_i && auto_mode_i && key_i && (amp_o <= scale_i)) && osk_en_i)
        |-> (amp_o <= $past(scale_i)));

    // R4
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osk_en_i && auto_mode_i && key_i && (amp_o <= scale_i)) && osk_en_i)
        |-> ((amp_o >= $past(amp_o)) && ((amp_o - $past(amp_o)) <= $past(step_i))));

    // R6
    fall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osk_en_i && auto_mode_i && !key_i) && osk_en_i) |-> (amp_o <= $past(amp_o)));
endmodule

bind osk_ctrl osk_ctrl_chk #(.AMP_W(AMP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .osk_en_i    (osk_en_i),
    .auto_mode_i (auto_mode_i),
    .key_i       (key_i),
    .scale_i     (scale_i),
    .step_i      (step_i),
    .amp_o       (amp_o)
);

// File: tb/osk_ctrl_tb_top.sv
module osk_ctrl_tb_top;
    localparam int AW = 14;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, autom = 1'b0, key = 1'b0;
    logic [AW-1:0] scale = '0, step = '0, ext = '0;
    logic [IW-1:0] ivl = '0;
    logic [AW-1:0] amp;

    int            total = 0;
    int            bad = 0;
    int            m_ramp = 0;
    int            m_cnt = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    osk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .osk_en_i(en), .auto_mode_i(autom), .key_i(key),
        .scale_i(scale), .step_i(step), .ivl_i(ivl), .amp_ext_i(ext), .amp_o(amp)
    );

    function automatic int ramp_next(int r, bit k, int sc, int st);
        if (k) return (r >= sc) ? sc : ((r + st > sc) ? sc : r + st);
        return (r > st) ? r - st : 0;
    endfunction

    function automatic int expect_amp();
        return en ? m_ramp : int'(ext);
    endfunction

    task automatic model_edge();
        int eff;
        bit tk;
        if (!en) begin
            m_cnt = 0; m_ramp = 0;
        end else if (!autom) begin
            m_cnt = 0; m_ramp = key ? int'(scale) : 0;
        end else begin
            eff = (ivl == 0) ? 1 : int'(ivl);
            tk  = (m_cnt >= eff - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            if (tk) m_ramp = ramp_next(m_ramp, key, int'(scale), int'(step));
        end
    endtask

    task automatic check(string tag);
        total++;
        if (int'(amp) != expect_amp()) begin
            bad++;
            $display("FAIL %s: amp_o=%0d expected=%0d at %0t", tag, amp, expect_amp(), $time);
        end
    endtask

    task automatic cyc(string tag, int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(tag);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        en = 1'b1; autom = 1'b1; key = 1'b1; scale = 14'd500; step = 14'd50; ivl = 16'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9");
        // R1 bypass, random external words
        en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ext = AW'($urandom(32'h1234 + i)); key = i[0]; autom = i[1];
            #0; check("R1"); cyc("R1");
        end
        // R2 / R3 manual switching
        en = 1'b1; autom = 1'b0; ext = 14'h3fff; scale = 14'd9000;
        key = 1'b1; cyc("R2", 2);
        key = 1'b0; cyc("R3", 2);
        key = 1'b1; scale = 14'd16383; cyc("R2");
        // R4 / R5 automatic rise and clamp
        key = 1'b0; cyc("R3");
        autom = 1'b1; key = 1'b1; scale = 14'd1000; step = 14'd150; ivl = 16'd3;
        cyc("R4", 12); cyc("R5", 30);
        // R7 lower scale mid-interval under parked ramp
        cyc("R7", 1); scale = 14'd320; cyc("R7", 6);
        // R6 fall to zero
        key = 1'b0; step = 14'd70; cyc("R6", 25);
        // R8 interval zero
        ivl = 16'd0; key = 1'b1; step = 14'd7; scale = 14'd40; cyc("R8", 10);
        // R10 disable then re-enable
        en = 1'b0; cyc("R10", 2);
        en = 1'b1; ivl = 16'd5; step = 14'd11; cyc("R10", 12);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom(32'hbeef0 + i) % 8 == 0) key = ~key;
            if ($urandom % 40 == 0) en = ~en;
            if ($urandom % 60 == 0) autom = ~autom;
            if ($urandom % 30 == 0) scale = AW'($urandom % 16384);
            if ($urandom % 50 == 0) step = AW'($urandom % 2048);
            if ($urandom % 80 == 0) ivl = IW'($urandom % 6);
            ext = AW'($urandom);
            cyc("R4");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule